// File: doc/BRIEF.md
# Interrupt Source Presented/Queued State Tracker

This block keeps the delivery state of a small bank of interrupt sources (16 by default). Each source has an 8-bit priority and a trigger mode, edge or level. Two state bits per source, presented and queued, decide whether a trigger is offered downstream at once or only recorded for later. An end-of-interrupt command for a source moves its queued bit into its presented bit. If that leaves the source presented, the block offers it downstream again.

Offers go out on one valid/ready channel that carries the source number and the current priority of that source. Offers that are waiting sit in a per-source pending register until they are accepted. The lowest source number goes first. A configuration port sets the priority and the mode of a source. A state port reads out the word of any source and writes it back, so that the bank can be saved and restored.

Top module: `irq_pq_tracker`

## Requirements
- R1: After reset every source reads state word 0, has priority 0xFF (masked) and edge mode, and `pres_valid_o` is low.
- R2: A trigger on an unmasked source whose presented bit (word bit 0) is clear sets that bit and makes a present request. An edge-mode source triggers in a cycle where its line is high and was low in the cycle before.
- R3: A trigger on an edge-mode source that is already presented makes no new request and sets the queued bit (word bit 1).
- R4: End of interrupt for a source copies the queued bit into the presented bit and clears the queued bit. If the presented bit is then set, a new present request is made.
- R5: A level-mode source triggers in every cycle its line is high. Its presented bit serves as its asserted flag, and it never sets the queued bit.
- R6: A trigger on a source with priority 0xFF sets the masked-pending bit (word bit 2) and makes no request.
- R7: Writing a priority other than 0xFF to a source whose masked-pending bit is set clears that bit and handles the write as a trigger.
- R8: When an end of interrupt and a trigger reach the same source in the same cycle, the end of interrupt is applied first.
- R9: A present request stays pending until it is accepted with `pres_ready_i` high. Among pending requests the lowest source number is offered, and acceptance clears only that request.
- R10: `st_rdata_o` returns {0, masked-pending, queued, presented} for the source chosen by `st_src_i`, in the same cycle.
- R11: A state write loads presented, queued and masked-pending from word bits 0 to 2. If word bit 3 (pending) is set, presented is forced to 1 and a present request is made.
- R12: `pres_prio_o` is the priority currently held for the offered source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line_i | input | NSRC | Interrupt lines, one per source |
| cfg_we_i | input | 1 | Write priority and mode |
| cfg_src_i | input | SRC_W | Source to configure |
| cfg_prio_i | input | 8 | New priority, 0xFF masks the source |
| cfg_level_i | input | 1 | 1 selects level mode, 0 selects edge mode |
| eoi_valid_i | input | 1 | End-of-interrupt command |
| eoi_src_i | input | SRC_W | Source that the end of interrupt applies to |
| st_src_i | input | SRC_W | Source for state read and write |
| st_rdata_o | output | 4 | State word of the selected source |
| st_we_i | input | 1 | Restore the selected source from `st_wdata_i` |
| st_wdata_i | input | 4 | Word to restore |
| pres_valid_o | output | 1 | A present request is offered |
| pres_ready_i | input | 1 | Downstream accepts the offer |
| pres_src_o | output | SRC_W | Source being offered |
| pres_prio_o | output | 8 | Priority of the offered source |

## Verification
Line changes, end-of-interrupt commands, configuration writes and restores each take effect at the next rising edge, one register stage. The state word is combinational from that register, so it can be read at the falling edge that follows. Edge detection compares the line with its value from the cycle before, so the bench changes the line in one cycle and expects the effect one edge later. The bench drives all inputs at falling edges and checks the state word, the valid flag, the offered source and its priority half a period after the edge that is expected to update them.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    localparam int WORD_W  = 4;
    localparam int WB_PRES = 0;
    localparam int WB_QUE  = 1;
    localparam int WB_MPND = 2;
    localparam int WB_PEND = 3;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              pres;
        logic              que;
        logic              mpend;
        logic              req;
    } src_st_t;

    localparam src_st_t SRC_RESET = '{prio: PRIO_MASKED, level: 1'b0, pres: 1'b0,
                                      que: 1'b0, mpend: 1'b0, req: 1'b0};
endpackage

// File: rtl/pq_slot.sv
module pq_slot
    import pq_pkg::*;
(
    input  src_st_t           cur,
    input  logic              line,
    input  logic              line_prev,
    input  logic              eoi_hit,
    input  logic              cfg_hit,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              cfg_level,
    input  logic              rst_hit,
    input  logic [WORD_W-1:0] rst_word,
    input  logic              grant,
    output src_st_t           nxt
);
    logic unmask;
    logic fire;

    always_comb begin
        nxt    = cur;
        unmask = 1'b0;
        fire   = 1'b0;
        nxt.req = cur.req & ~grant;
        if (rst_hit) begin
            nxt.pres  = rst_word[WB_PRES] | rst_word[WB_PEND];
            nxt.que   = rst_word[WB_QUE];
            nxt.mpend = rst_word[WB_MPND];
            nxt.req   = nxt.req | rst_word[WB_PEND];
        end else begin
            if (cfg_hit) begin
                nxt.prio  = cfg_prio;
                nxt.level = cfg_level;
                if (cfg_prio != PRIO_MASKED && cur.mpend) begin
                    nxt.mpend = 1'b0;
                    unmask    = 1'b1;
                end
            end
            // end of interrupt goes first, then any trigger of this cycle
            if (eoi_hit) begin
                nxt.pres = cur.que;
                nxt.que  = 1'b0;
                if (cur.que) nxt.req = 1'b1;
            end
            fire = (nxt.level ? line : (line & ~line_prev)) | unmask;
            if (fire) begin
                if (nxt.prio == PRIO_MASKED) begin
                    nxt.mpend = 1'b1;
                end else if (!nxt.pres) begin
                    nxt.pres = 1'b1;
                    nxt.req  = 1'b1;
                end else if (!nxt.level) begin
                    nxt.que = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pq_pick.sv
module pq_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_pq_tracker.sv
module irq_pq_tracker
    import pq_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int SRC_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_line_i,
    input  logic              cfg_we_i,
    input  logic [SRC_W-1:0]  cfg_src_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic              cfg_level_i,
    input  logic              eoi_valid_i,
    input  logic [SRC_W-1:0]  eoi_src_i,
    input  logic [SRC_W-1:0]  st_src_i,
    output logic [WORD_W-1:0] st_rdata_o,
    input  logic              st_we_i,
    input  logic [WORD_W-1:0] st_wdata_i,
    output logic              pres_valid_o,
    input  logic              pres_ready_i,
    output logic [SRC_W-1:0]  pres_src_o,
    output logic [PRIO_W-1:0] pres_prio_o
);
    src_st_t         st_q [NSRC];
    src_st_t         st_d [NSRC];
    src_st_t         slot_nxt [NSRC];
    logic [NSRC-1:0] line_q, line_d;
    logic [NSRC-1:0] req_vec;
    logic [NSRC-1:0] q_vec;
    logic [NSRC-1:0] grant_vec;
    logic            pick_any;
    logic [SRC_W-1:0] pick_idx;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign req_vec[i]   = st_q[i].req;
        assign q_vec[i]     = st_q[i].que;
        assign grant_vec[i] = pick_any && pres_ready_i && (pick_idx == SRC_W'(i));

        pq_slot u_slot (
            .cur       (st_q[i]),
            .line      (src_line_i[i]),
            .line_prev (line_q[i]),
            .eoi_hit   (eoi_valid_i && (eoi_src_i == SRC_W'(i))),
            .cfg_hit   (cfg_we_i && (cfg_src_i == SRC_W'(i))),
            .cfg_prio  (cfg_prio_i),
            .cfg_level (cfg_level_i),
            .rst_hit   (st_we_i && (st_src_i == SRC_W'(i))),
            .rst_word  (st_wdata_i),
            .grant     (grant_vec[i]),
            .nxt       (slot_nxt[i])
        );
    end

    pq_pick #(.N(NSRC), .IDX_W(SRC_W)) u_pick (
        .req (req_vec),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        line_d = src_line_i;
        for (int i = 0; i < NSRC; i++) st_d[i] = slot_nxt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            for (int i = 0; i < NSRC; i++) st_q[i] <= SRC_RESET;
        end else begin
            line_q <= line_d;
            for (int i = 0; i < NSRC; i++) st_q[i] <= st_d[i];
        end
    end

    assign pres_valid_o = pick_any;
    assign pres_src_o   = pick_idx;
    assign pres_prio_o  = st_q[pick_idx].prio;
    assign st_rdata_o   = {1'b0, st_q[st_src_i].mpend, st_q[st_src_i].que, st_q[st_src_i].pres};
endmodule

// File: rtl/irq_pq_tracker_chk.sv
module irq_pq_tracker_chk #(
    parameter int NSRC  = 16,
    parameter int SRC_W = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pres_valid,
    input logic             pres_ready,
    input logic [SRC_W-1:0] pres_src,
    input logic [NSRC-1:0]  req_vec,
    input logic [NSRC-1:0]  q_vec,
    input logic             eoi_valid,
    input logic [SRC_W-1:0] eoi_src,
    input logic             st_we,
    input logic [SRC_W-1:0] st_src
);
    logic [NSRC-1:0] below_mask;
    assign below_mask = (NSRC'(1) << pres_src) - NSRC'(1);

    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid && !pres_ready |=> pres_valid);

    a_r9_offer_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> req_vec[pres_src]);

    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> ((req_vec & below_mask) == '0));

    a_r4_eoi_leaves_q_clear: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid && !q_vec[eoi_src] && !(st_we && st_src == eoi_src)
        |=> !q_vec[$past(eoi_src)]);
endmodule

bind irq_pq_tracker irq_pq_tracker_chk #(.NSRC(NSRC), .SRC_W(SRC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pres_valid (pres_valid_o),
    .pres_ready (pres_ready_i),
    .pres_src   (pres_src_o),
    .req_vec    (req_vec),
    .q_vec      (q_vec),
    .eoi_valid  (eoi_valid_i),
    .eoi_src    (eoi_src_i),
    .st_we      (st_we_i),
    .st_src     (st_src_i)
);

// File: tb/irq_pq_tracker_bench.sv
module irq_pq_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] src_line_i;
    logic        cfg_we_i;
    logic [3:0]  cfg_src_i;
    logic [7:0]  cfg_prio_i;
    logic        cfg_level_i;
    logic        eoi_valid_i;
    logic [3:0]  eoi_src_i;
    logic [3:0]  st_src_i;
    logic [3:0]  st_rdata_o;
    logic        st_we_i;
    logic [3:0]  st_wdata_i;
    logic        pres_valid_o;
    logic        pres_ready_i;
    logic [3:0]  pres_src_o;
    logic [7:0]  pres_prio_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles++;

    irq_pq_tracker u_irq_pq_tracker (.*);

    typedef struct packed {
        logic [15:0] line;
        logic        eoi;
        logic [3:0]  esrc;
        logic        rdy;
        logic [3:0]  watch;
        logic [3:0]  word;
        logic        vld;
        logic [3:0]  psrc;
        logic [7:0]  req;
    } vec_t;

    // src2 edge prio 5, src5 level prio 9, src7 edge prio 3, src9 left masked
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{16'h0004, 1'b0, 4'd0, 1'b0, 4'd2, 4'd1, 1'b1, 4'd2, 8'd2},  // R2 first edge
        '{16'h0000, 1'b0, 4'd0, 1'b0, 4'd2, 4'd1, 1'b1, 4'd2, 8'd9},  // R9 held
        '{16'h0004, 1'b0, 4'd0, 1'b0, 4'd2, 4'd3, 1'b1, 4'd2, 8'd3},  // R3 queued
        '{16'h0000, 1'b0, 4'd0, 1'b1, 4'd2, 4'd3, 1'b0, 4'd0, 8'd9},  // R9 accepted
        '{16'h0000, 1'b1, 4'd2, 1'b0, 4'd2, 4'd1, 1'b1, 4'd2, 8'd4},  // R4 promote
        '{16'h0000, 1'b0, 4'd0, 1'b1, 4'd2, 4'd1, 1'b0, 4'd0, 8'd9},  // R9 accepted
        '{16'h0000, 1'b1, 4'd2, 1'b0, 4'd2, 4'd0, 1'b0, 4'd0, 8'd4},  // R4 clear
        '{16'h0004, 1'b1, 4'd2, 1'b0, 4'd2, 4'd1, 1'b1, 4'd2, 8'd8},  // R8 eoi then trigger
        '{16'h0004, 1'b1, 4'd2, 1'b0, 4'd2, 4'd0, 1'b1, 4'd2, 8'd4},  // R4 no edge, request kept
        '{16'h0080, 1'b0, 4'd0, 1'b0, 4'd7, 4'd1, 1'b1, 4'd2, 8'd9},  // R9 lowest wins
        '{16'h0080, 1'b0, 4'd0, 1'b1, 4'd7, 4'd1, 1'b1, 4'd7, 8'd9},  // R9 next one
        '{16'h0000, 1'b0, 4'd0, 1'b1, 4'd7, 4'd1, 1'b0, 4'd0, 8'd9},  // R9 drained
        '{16'h0020, 1'b0, 4'd0, 1'b0, 4'd5, 4'd1, 1'b1, 4'd5, 8'd5},  // R5 level asserts
        '{16'h0020, 1'b0, 4'd0, 1'b0, 4'd5, 4'd1, 1'b1, 4'd5, 8'd5},  // R5 no queue
        '{16'h0020, 1'b0, 4'd0, 1'b1, 4'd5, 4'd1, 1'b0, 4'd0, 8'd5},  // R5 accepted
        '{16'h0020, 1'b1, 4'd5, 1'b0, 4'd5, 4'd1, 1'b1, 4'd5, 8'd5},  // R5 still high re-presents
        '{16'h0000, 1'b1, 4'd5, 1'b1, 4'd5, 4'd0, 1'b0, 4'd0, 8'd5},  // R5 released
        '{16'h0200, 1'b0, 4'd0, 1'b0, 4'd9, 4'd4, 1'b0, 4'd0, 8'd6}   // R6 masked
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        src_line_i = '0; cfg_we_i = 0; cfg_src_i = 0; cfg_prio_i = 0; cfg_level_i = 0;
        eoi_valid_i = 0; eoi_src_i = 0; st_we_i = 0; st_wdata_i = 0; pres_ready_i = 0;
    endtask

    task automatic cfg(input int s, input int p, input logic lvl);
        @(negedge clk);
        cfg_we_i = 1; cfg_src_i = 4'(s); cfg_prio_i = 8'(p); cfg_level_i = lvl;
        @(negedge clk);
        cfg_we_i = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        while (cycles < 5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
        finish_run();
    end

    initial begin
        idle();
        st_src_i = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", pres_valid_o, 0);
        for (int s = 0; s < 16; s += 5) begin
            st_src_i = 4'(s);
            #1;
            chk("R1 word", st_rdata_o, 0);
        end

        cfg(2, 5, 1'b0);
        cfg(5, 9, 1'b1);
        cfg(7, 3, 1'b0);
        chk("R1 no request after config", pres_valid_o, 0);

        for (int v = 0; v < NV; v++) begin
            src_line_i   = VECS[v].line;
            eoi_valid_i  = VECS[v].eoi;
            eoi_src_i    = VECS[v].esrc;
            pres_ready_i = VECS[v].rdy;
            st_src_i     = VECS[v].watch;
            @(negedge clk);
            chk($sformatf("R%0d vec %0d word", VECS[v].req, v), st_rdata_o, VECS[v].word);
            chk($sformatf("R%0d vec %0d valid", VECS[v].req, v), pres_valid_o, VECS[v].vld);
            if (VECS[v].vld)
                chk($sformatf("R%0d vec %0d src", VECS[v].req, v), pres_src_o, VECS[v].psrc);
        end
        idle();

        // R7 unmask turns the recorded trigger into a presentation
        st_src_i = 9;
        cfg(9, 2, 1'b0);
        chk("R7 word", st_rdata_o, 1);
        chk("R7 valid", pres_valid_o, 1);
        chk("R7 src", pres_src_o, 9);
        chk("R12 prio", pres_prio_o, 2);
        pres_ready_i = 1;
        @(negedge clk);
        pres_ready_i = 0;
        chk("R9 drained", pres_valid_o, 0);

        // R11 restore with pending forces presented and requests
        st_src_i = 11; st_we_i = 1; st_wdata_i = 4'b1000;
        @(negedge clk);
        st_we_i = 0;
        chk("R11 word", st_rdata_o, 1);
        chk("R11 valid", pres_valid_o, 1);
        chk("R11 src", pres_src_o, 11);
        chk("R12 masked prio", pres_prio_o, 255);

        // R10 restored queued bit reads back, no request added
        st_src_i = 12; st_we_i = 1; st_wdata_i = 4'b0010;
        @(negedge clk);
        st_we_i = 0;
        chk("R10 word", st_rdata_o, 2);
        chk("R10 src unchanged", pres_src_o, 11);
        st_src_i = 11;
        #1;
        chk("R10 other word", st_rdata_o, 1);

        finish_run();
    end
endmodule